// File: doc/BRIEF.md
# Serial Shift-and-Store Output Register

This block is a serial-in, parallel-out register with a separate holding stage. Serial data enters a chain of flip-flops, one bit per rising clock edge. A holding stage copies the whole chain while the strobe input is high and keeps its last copy while the strobe is low. A host can therefore shift a new word in without disturbing the word that is currently presented, and then publish the new word in a single strobe pulse.

The presented word leaves the block as a data vector together with a drive-enable vector. Every bit of the enable vector follows the output-enable input, so a pad wrapper can turn the pair into three-state pins. Two serial outputs carry the last stage onward so that several blocks can be chained. One of them changes on the rising edge, at the same time as the shift. The other is the same bit retimed to the following falling edge. This gives a downstream block a half-period of margin when its clock arrives late.

The holding stage has two modes. In the transparent mode it is a level-sensitive latch: it follows the chain while the strobe is high and holds while the strobe is low. In the edge mode, intended for FPGA targets, it captures on the rising edge whenever the strobe is high. There is no other control state.

Top module: `shift_store_reg`

## Requirements
- R1: An active-low asynchronous reset clears the chain, the holding stage and both serial outputs to 0, whatever the clock is doing.
- R2: On every rising clock edge, stage 0 takes `ser_in` and each stage k>0 takes the previous value of stage k-1.
- R3: While `strobe` is high, `par_data` equals the chain contents. In the transparent mode this holds within the same cycle that `strobe` rises.
- R4: While `strobe` stays low, `par_data` keeps its value, whatever data is shifted in.
- R5: `par_drive` is all ones while `oe` is 1 and all zeros while `oe` is 0. `par_data` carries the held word in both cases.
- R6: `oe` has no effect on shifting, on the held word or on either serial output.
- R7: `casc_rise` presents the last stage and changes only on the rising edge, together with the shift.
- R8: `casc_fall` takes the value of `casc_rise` on each falling edge and changes at no other time.
- R9: Stage 0 drives `par_data[0]` and the last stage drives `par_data[STAGES-1]`. After STAGES shifts, the first bit that entered appears on the most significant bit.
- R10: A second block whose `ser_in` is fed from `casc_rise` on the same clock behaves as a chain twice as long. The same holds for a second block fed from `casc_fall` whose rising edge arrives up to a quarter period late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | Holding-stage transfer control, active high |
| oe | input | 1 | Parallel output drive enable, active high |
| par_data | output | STAGES | Held word |
| par_drive | output | STAGES | Per-bit drive enable for a three-state wrapper |
| casc_rise | output | 1 | Last stage, updated on the rising edge |
| casc_fall | output | 1 | Last stage, retimed to the falling edge |

## Verification
The shift and the transfer into the holding stage can happen in the same cycle. When `strobe` is held high across a rising edge, the new chain contents must reach `par_data` before the end of that cycle. When `strobe` is dropped right after an edge, the word that was captured at that edge must stay fixed. The bench provokes both cases by raising and dropping the strobe in the middle of a shifting sequence while toggling `oe`. A reference model, stepped at the same edges, predicts each cycle's held word, serial outputs and the contents of the two chained blocks. `casc_fall` is sampled both before and after each falling edge.

// File: rtl/shstr_pkg.sv
package shstr_pkg;
    typedef enum logic {
        STORE_LATCH = 1'b0,
        STORE_EDGE  = 1'b1
    } store_style_e;

    localparam int unsigned DEF_STAGES = 8;
endpackage

// File: rtl/shstr_shift_chain.sv
module shstr_shift_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] chain_q,
    output logic [STAGES-1:0] chain_next,
    output logic              last_q
);
    assign chain_next = {chain_q[STAGES-2:0], ser_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_next;
    end

    assign last_q = chain_q[STAGES-1];
endmodule

// File: rtl/shstr_hold_stage.sv
module shstr_hold_stage
    import shstr_pkg::*;
#(
    parameter int unsigned  STAGES = 8,
    parameter store_style_e STYLE  = STORE_LATCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [STAGES-1:0] chain_now,
    input  logic [STAGES-1:0] chain_next,
    output logic [STAGES-1:0] held
);
    generate
        if (STYLE == STORE_LATCH) begin : g_latch
            wire unused_edge_inputs = ^{clk, chain_next};
            always_latch begin
                if (!rst_n)      held <= '0;
                else if (strobe) held <= chain_now;
            end
        end else begin : g_edge
            wire unused_level_inputs = ^chain_now;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      held <= '0;
                else if (strobe) held <= chain_next;
            end
        end
    endgenerate
endmodule

// File: rtl/shstr_fall_retime.sv
module shstr_fall_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic bit_out
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) bit_out <= 1'b0;
        else        bit_out <= bit_in;
    end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
    import shstr_pkg::*;
#(
    parameter int unsigned  STAGES = DEF_STAGES,
    parameter store_style_e STYLE  = STORE_LATCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              oe,
    output logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] par_drive,
    output logic              casc_rise,
    output logic              casc_fall
);
    logic [STAGES-1:0] shift_q;
    logic [STAGES-1:0] shift_d;

    shstr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .chain_q    (shift_q),
        .chain_next (shift_d),
        .last_q     (casc_rise)
    );

    shstr_hold_stage #(.STAGES(STAGES), .STYLE(STYLE)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .chain_now  (shift_q),
        .chain_next (shift_d),
        .held       (par_data)
    );

    shstr_fall_retime u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (casc_rise),
        .bit_out (casc_fall)
    );

    assign par_drive = {STAGES{oe}};
endmodule

// File: rtl/shstr_checker.sv
module shstr_checker #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_in,
    input logic              strobe,
    input logic [STAGES-1:0] shift_q,
    input logic [STAGES-1:0] par_data,
    input logic              casc_rise,
    input logic              casc_fall
);
    // R2: chain moves one place per edge
    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (shift_q == {$past(shift_q[STAGES-2:0]), $past(ser_in)}));

    // R7: serial output follows the stage below the last one
    a_r7_rise_advances: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (casc_rise == $past(shift_q[STAGES-2])));

    // R3: strobe held across an edge leaves the held word equal to the chain
    a_r3_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> (par_data == shift_q));

    // R4: strobe low on both samples keeps the held word
    a_r4_strobe_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !$past(strobe)) |-> $stable(par_data));

    // R8: at each rising edge the retimed bit equals the pre-edge last stage
    a_r8_fall_matches_rise: assert property (@(posedge clk) disable iff (!rst_n)
        casc_fall == casc_rise);
endmodule

bind shift_store_reg shstr_checker #(.STAGES(STAGES)) u_shstr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .strobe    (strobe),
    .shift_q   (shift_q),
    .par_data  (par_data),
    .casc_rise (casc_rise),
    .casc_fall (casc_fall)
);

// File: tb/test_shift_store_reg.sv
module test_shift_store_reg;
    localparam int unsigned W = 8;

    logic clk = 1'b0;
    logic clk_late;
    logic rst_n, ser_in, strobe, oe;
    logic [W-1:0] par_data, par_drive;
    logic casc_rise, casc_fall;
    logic [W-1:0] tb_data, tb_drive, tc_data, tc_drive;
    logic tb_rise, tb_fall, tc_rise, tc_fall;

    always #4 clk = ~clk;
    assign #2 clk_late = clk;

    shift_store_reg i_shift_store_reg (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe), .oe(oe),
        .par_data(par_data), .par_drive(par_drive),
        .casc_rise(casc_rise), .casc_fall(casc_fall));

    shift_store_reg i_tail_rise (
        .clk(clk), .rst_n(rst_n), .ser_in(casc_rise), .strobe(1'b1), .oe(1'b1),
        .par_data(tb_data), .par_drive(tb_drive),
        .casc_rise(tb_rise), .casc_fall(tb_fall));

    shift_store_reg i_tail_fall (
        .clk(clk_late), .rst_n(rst_n), .ser_in(casc_fall), .strobe(1'b1), .oe(1'b1),
        .par_data(tc_data), .par_drive(tc_drive),
        .casc_rise(tc_rise), .casc_fall(tc_fall));

    typedef struct {
        logic [W-1:0] data;
        logic [W-1:0] drive;
        logic         rise;
        logic         fall_early;
        logic [W-1:0] tail;
    } exp_t;

    exp_t sb[$];
    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    logic [2*W-1:0] m_chain;
    logic [W-1:0]   m_store;
    logic           m_prev_rise;
    logic [15:0]    lfsr = 16'hACE1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_chain = '0;
        m_store = '0;
        m_prev_rise = 1'b0;
    endtask

    // called at rising edge + 1
    task automatic step(input logic d, input logic stb, input logic o);
        exp_t it;
        ser_in = d; strobe = stb; oe = o;
        if (stb) m_store = m_chain[W-1:0];
        it.data = m_store;
        it.drive = {W{o}};
        it.rise = m_chain[W-1];
        it.fall_early = m_prev_rise;
        it.tail = m_chain[2*W-1:W];
        sb.push_back(it);
        @(posedge clk);
        m_prev_rise = m_chain[W-1];
        m_chain = {m_chain[2*W-2:0], d};
        if (stb) m_store = m_chain[W-1:0];
        #1;
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // scoreboard monitor
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check("R3 R4 held word", par_data, it.data);
                check("R5 drive", par_drive, it.drive);
                check("R7 casc_rise", casc_rise, it.rise);
                check("R8 casc_fall before fall edge", casc_fall, it.fall_early);
                check("R10 tail via casc_rise", tb_data, it.tail);
                check("R10 tail via casc_fall late clock", tc_data, it.tail);
                #2;
                check("R8 casc_fall after fall edge", casc_fall, it.rise);
            end
        end
    end

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            finish_up();
        end
    end

    initial begin
        rst_n = 1'b0; ser_in = 1'b1; strobe = 1'b1; oe = 1'b0;
        model_clear();
        @(posedge clk); #1;
        check("R1 reset held word", par_data, '0);
        check("R1 reset casc_rise", casc_rise, 0);
        check("R1 reset casc_fall", casc_fall, 0);
        check("R5 drive off", par_drive, '0);
        rst_n = 1'b1; ser_in = 1'b0;

        // R2 R9: load 8'hB4 msb first, strobe high
        for (int i = W - 1; i >= 0; i--) step(8'hB4 >> i, 1'b1, 1'b1);
        check("R2 R9 bit order", par_data, 8'hB4);

        // R4: strobe low while new data shifts
        for (int i = 0; i < 8; i++) step(next_bit(), 1'b0, 1'b1);
        check("R4 hold after shifting", par_data, 8'hB4);

        // R3: raise strobe mid-sequence, transparent in same cycle
        ser_in = 1'b1; strobe = 1'b1;
        #1;
        check("R3 transparent mid-cycle", par_data, m_chain[W-1:0]);
        step(1'b1, 1'b1, 1'b1);

        // strobe toggling mid-sequence
        for (int i = 0; i < 24; i++) step(next_bit(), (i % 5) < 2, 1'b1);

        // R6: oe toggling during shifting
        for (int i = 0; i < 24; i++) step(next_bit(), (i % 3) != 0, i[0]);
        oe = 1'b0;
        #1;
        check("R6 held word with oe low", par_data, m_store);
        check("R6 casc_rise with oe low", casc_rise, m_chain[W-1]);
        check("R5 drive off again", par_drive, '0);

        // long random run through both cascades
        for (int i = 0; i < 64; i++) step(next_bit(), 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);

        // R1: asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        check("R1 async reset word", par_data, '0);
        check("R1 async reset casc_rise", casc_rise, 0);
        check("R1 async reset casc_fall", casc_fall, 0);
        check("R1 async reset tail", tb_data, '0);
        model_clear();
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) step(next_bit(), 1'b1, 1'b1);

        @(posedge clk); #6;
        done = 1;
        finish_up();
    end
endmodule